// File: doc/BRIEF.md
# Pixel Stream Alignment Buffer

This block takes two pixel streams that carry the same frame timing but arrive with a skew of several lines. The early stream is written into a circular RAM, and the RAM address at which each of its lines begins is recorded. The later stream is the reference stream. Each time a reference line starts, the block reads the matching early line back from the RAM. Both streams then leave the block on one shared control bus, and that bus is the reference control delayed by a fixed latency.

Each stream has a pixel word and a 5-bit control vector. In that vector, bit 4 is line start, bit 3 is line end, bit 2 is frame start, bit 1 is frame end and bit 0 is pixel valid. The circular RAM holds 2^(MAX_LINES + log2(LINE_BUF_SIZE)) pixels. The FIFO of line start addresses holds MAX_LINES entries. A single register keeps the RAM address of the early frame start. Typical uses are overlaying or combining a processed stream with its own source. In such a pairing, the processed stream arrives late and acts as the reference.

Top module: `pix_stream_align`

## Requirements
- R1: `ctl_out` equals `ref_ctl_in` delayed by exactly 10 clock cycles.
- R2: `ref_pix_out` equals `ref_pix_in` delayed by exactly 10 clock cycles.
- R3: When `ctl_out` bit 0 (valid) is high, `pix_out` carries the early-stream pixel at the same line and pixel position as the reference pixel now on `ref_pix_out`.
- R4: When `ctl_out` bit 0 is low, `pix_out` is zero.
- R5: While `rst_n` is low, all outputs are zero.
- R6: The write address advances by one only on cycles with early valid high, and it wraps modulo the RAM size. Lines stored across the wrap point read back correctly.
- R7: Early cycles with valid low neither store a pixel nor consume an address. Lines with gaps in valid therefore still align pixel for pixel.
- R8: A skew of exactly MAX_LINES lines aligns correctly. This is the case where MAX_LINES early line starts (bit 4 with valid) occur before the first reference line start.
- R9: At a reference frame start (bits 2 and 0 high), the stored early frame start address equals the oldest line start address held in the FIFO.
- R10: The line FIFO pushes on each early line start with valid and pops on each reference line start with valid. Its level never exceeds MAX_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | PIX_W | Early-stream pixel |
| ctl_in | input | 5 | Early-stream control {line start, line end, frame start, frame end, valid} |
| ref_pix_in | input | PIX_W | Reference-stream pixel |
| ref_ctl_in | input | 5 | Reference-stream control, same bit order |
| pix_out | output | PIX_W | Aligned early pixel, zero when not valid |
| ref_pix_out | output | PIX_W | Delayed reference pixel |
| ctl_out | output | 5 | Shared delayed reference control |

## Verification
Several checks run on every cycle: the 10-cycle delay of the reference pixel and control, zero on the aligned output when valid is low, the write address stepping only on valid, the FIFO level rules, and agreement of the frame start address with the FIFO head. Content alignment cannot be seen from single-cycle relations. That covers the right early pixel appearing beside each reference pixel, across valid gaps, across the RAM wrap, and at the largest allowed skew. Only the bench's multi-frame scenarios can show it, using a scoreboard that predicts every output word.

// File: rtl/pix_align_pkg.sv
package pix_align_pkg;
  localparam int CTL_W      = 5;
  localparam int CTL_VALID  = 0;
  localparam int CTL_VEND   = 1;
  localparam int CTL_VSTART = 2;
  localparam int CTL_HEND   = 3;
  localparam int CTL_HSTART = 4;
  // total latency from reference inputs to all outputs
  localparam int ALIGN_LAT  = 10;

  function automatic int ring_bits(input int max_lines, input int line_buf);
    return max_lines + $clog2(line_buf);
  endfunction

  function automatic int ptr_step(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/align_ring_ram.sv
module align_ring_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/align_line_fifo.sv
module align_line_fifo import pix_align_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign head = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ptr_step(int'(rd_ptr), DEPTH));
      if (push && !pop)      level <= level + CW'(1);
      else if (pop && !push) level <= level - CW'(1);
    end
  end
endmodule

// File: rtl/align_delay.sv
module align_delay #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [N];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[N-1];
endmodule

// File: rtl/pix_stream_align.sv
module pix_stream_align import pix_align_pkg::*; #(
  parameter int PIX_W         = 8,
  parameter int MAX_LINES     = 4,
  parameter int LINE_BUF_SIZE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic [PIX_W-1:0] ref_pix_in,
  input  logic [CTL_W-1:0] ref_ctl_in,
  output logic [PIX_W-1:0] pix_out,
  output logic [PIX_W-1:0] ref_pix_out,
  output logic [CTL_W-1:0] ctl_out
);
  localparam int AW          = ring_bits(MAX_LINES, LINE_BUF_SIZE);
  localparam int CW          = $clog2(MAX_LINES+1);
  localparam int DATA_STAGES = ALIGN_LAT - 2;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // named events for the checker
  logic          early_valid, fifo_push, early_frame;
  logic          ref_valid, fifo_pop, ref_frame_ev;
  logic [AW-1:0] wr_addr, frame_start_q, fifo_head;
  logic [CW-1:0] fifo_level;

  assign early_valid  = ctl_in[CTL_VALID];
  assign fifo_push    = ctl_in[CTL_HSTART] & early_valid;
  assign early_frame  = ctl_in[CTL_VSTART] & early_valid;
  assign ref_valid    = ref_ctl_in[CTL_VALID];
  assign fifo_pop     = ref_ctl_in[CTL_HSTART] & ref_valid;
  assign ref_frame_ev = ref_ctl_in[CTL_VSTART] & ref_valid;

  // write side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr       <= '0;
      frame_start_q <= '0;
    end else begin
      if (early_valid) wr_addr <= addr_next(wr_addr);
      if (early_frame) frame_start_q <= wr_addr;
    end
  end

  align_line_fifo #(.DEPTH(MAX_LINES), .DW(AW)) line_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .push_data(wr_addr),
    .pop(fifo_pop), .head(fifo_head), .level(fifo_level)
  );

  // read side
  logic [AW-1:0] line_base, rd_addr_d, rd_ptr_q, rd_addr_q;
  logic [PIX_W-1:0] ram_q, data_dly;

  assign line_base = ref_frame_ev ? frame_start_q : fifo_head;
  assign rd_addr_d = fifo_pop ? line_base : rd_ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q  <= '0;
      rd_addr_q <= '0;
    end else begin
      if (ref_valid) rd_ptr_q <= addr_next(rd_addr_d);
      rd_addr_q <= rd_addr_d;
    end
  end

  align_ring_ram #(.AW(AW), .DW(PIX_W)) ring_i (
    .clk(clk), .we(early_valid), .waddr(wr_addr), .wdata(pix_in),
    .raddr(rd_addr_q), .rdata(ram_q)
  );

  align_delay #(.W(PIX_W), .N(DATA_STAGES)) data_dly_i (
    .clk(clk), .rst_n(rst_n), .d(ram_q), .q(data_dly)
  );

  align_delay #(.W(PIX_W+CTL_W), .N(ALIGN_LAT)) ref_dly_i (
    .clk(clk), .rst_n(rst_n), .d({ref_pix_in, ref_ctl_in}),
    .q({ref_pix_out, ctl_out})
  );

  assign pix_out = ctl_out[CTL_VALID] ? data_dly : '0;
endmodule

// File: rtl/pix_align_chk.sv
module pix_align_chk import pix_align_pkg::*; #(
  parameter int PIX_W     = 8,
  parameter int AW        = 8,
  parameter int CW        = 3,
  parameter int MAX_LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ref_ctl_in,
  input logic [PIX_W-1:0] ref_pix_in,
  input logic [CTL_W-1:0] ctl_out,
  input logic [PIX_W-1:0] ref_pix_out,
  input logic [PIX_W-1:0] pix_out,
  input logic             early_valid,
  input logic             early_frame,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic [CW-1:0]    fifo_level,
  input logic [AW-1:0]    fifo_head,
  input logic [AW-1:0]    frame_start_q,
  input logic             ref_frame_ev,
  input logic [AW-1:0]    wr_addr
);
  logic [3:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  // R1
  ctl_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 4'hF) |-> ctl_out == $past(ref_ctl_in, 10));
  // R2
  ref_pix_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 4'hF) |-> ref_pix_out == $past(ref_pix_in, 10));
  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_out[CTL_VALID] |-> pix_out == '0);
  // R6
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 4'h0) |=> wr_addr == AW'($past(wr_addr) + AW'($past(early_valid))));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 4'h0 && !early_valid) |=> $stable(wr_addr));
  // R9
  frame_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_frame_ev |-> fifo_head == frame_start_q);
  // R9
  frame_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 4'h0 && early_frame) |=> frame_start_q == $past(wr_addr));
  // R10
  fifo_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 4'h0 && fifo_push && !fifo_pop) |=> fifo_level == CW'($past(fifo_level) + 1'b1));
  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(MAX_LINES));
endmodule

bind pix_stream_align pix_align_chk #(
  .PIX_W(PIX_W), .AW(AW), .CW(CW), .MAX_LINES(MAX_LINES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_ctl_in(ref_ctl_in), .ref_pix_in(ref_pix_in),
  .ctl_out(ctl_out), .ref_pix_out(ref_pix_out), .pix_out(pix_out),
  .early_valid(early_valid), .early_frame(early_frame),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_level(fifo_level),
  .fifo_head(fifo_head), .frame_start_q(frame_start_q),
  .ref_frame_ev(ref_frame_ev), .wr_addr(wr_addr)
);

// File: tb/pix_stream_align_tb_top.sv
module pix_stream_align_tb_top;
  localparam int LP = 20, SLOTS = 14, LINES = 6, FP = 160, NF = 5, LAT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pix_in = '0, ref_pix_in = '0;
  logic [4:0] ctl_in = '0, ref_ctl_in = '0;
  logic [7:0] pix_out, ref_pix_out;
  logic [4:0] ctl_out;

  always #10 clk = ~clk;

  pix_stream_align dut_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .ctl_in(ctl_in),
    .ref_pix_in(ref_pix_in), .ref_ctl_in(ref_ctl_in),
    .pix_out(pix_out), .ref_pix_out(ref_pix_out), .ctl_out(ctl_out)
  );

  typedef struct {
    logic [4:0] ctl;
    logic [7:0] rpix;
    logic [7:0] pix;
    int         tag;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;

  // frame timing model: bit4 line start, bit3 line end, bit2 frame start, bit1 frame end, bit0 valid
  task automatic gen(input int t, output logic [4:0] c, output logic [7:0] v,
                     output int fr, output int ln);
    int r, s;
    c = '0; v = '0; fr = 0; ln = 0;
    if (t < 0) return;
    fr = t / FP; r = t % FP; ln = r / LP; s = r % LP;
    if (fr >= NF || ln >= LINES || s >= SLOTS) return;
    c[0] = !(s == 6 && ln % 2 == 0);
    c[4] = (s == 0);
    c[3] = (s == SLOTS - 1);
    c[2] = (s == 0 && ln == 0);
    c[1] = (s == SLOTS - 1 && ln == LINES - 1);
    v = 8'((fr * 53 + ln * 17 + s * 5 + 3) & 255);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic monitor_step();
    exp_t e;
    if (sb.size() < LAT) return;
    e = sb.pop_front();
    check("R1", {3'b0, ctl_out}, {3'b0, e.ctl});
    check("R2", ref_pix_out, e.rpix);
    case (e.tag)
      4: check("R4", pix_out, e.pix);
      6: check("R6", pix_out, e.pix);
      7: check("R7", pix_out, e.pix);
      8: check("R8", pix_out, e.pix);
      default: check("R3", pix_out, e.pix);
    endcase
  endtask

  task automatic drive_step(input int t, input int skew_lines);
    logic [4:0] ce, cr;
    logic [7:0] ve, vr;
    int fe, le, fr, lr;
    exp_t e;
    gen(t, ce, ve, fe, le);
    gen(t - skew_lines * LP, cr, vr, fr, lr);
    ctl_in     = ce;
    pix_in     = ce[0] ? ve : 8'hA5;
    ref_ctl_in = cr;
    ref_pix_in = cr[0] ? ~vr : 8'h5A;
    e.ctl  = cr;
    e.rpix = ref_pix_in;
    e.pix  = cr[0] ? vr : 8'h00;
    if (!cr[0])              e.tag = 4;
    else if (fr >= 3)        e.tag = 6;
    else if (lr % 2 == 0)    e.tag = 7;
    else if (skew_lines == 4) e.tag = 8;
    else                     e.tag = 3;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctl_in = '0; pix_in = 8'hFF; ref_ctl_in = '0; ref_pix_in = 8'hFF;
    repeat (12) @(negedge clk);
    // R5: everything quiet during reset
    check("R5", pix_out, 8'h00);
    check("R5", ref_pix_out, 8'h00);
    check("R5", {3'b0, ctl_out}, 8'h00);
    rst_n = 1'b1;
    sb.delete();
  endtask

  task automatic run_scenario(input int skew_lines);
    do_reset();
    for (int t = 0; t < NF * FP + skew_lines * LP + 30; t++) begin
      @(negedge clk);
      monitor_step();
      drive_step(t, skew_lines);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_scenario(2);
    run_scenario(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule